// File: doc/BRIEF.md
# Chunked Instruction Queue Fetcher

This block keeps the pending work of a single instruction queue and turns it into memory read requests. Software adds work by writing a count of 64-bit words to a doorbell register. Every instruction is 8 words long, which is 64 bytes. Instructions sit in memory chunks, and each chunk is linked to the next. A chunk holds 8n+1 words: n instructions, then one link word that carries the address of the next chunk.

While the queue is enabled and at least one instruction is pending, the block requests instructions one at a time, starting from the current fetch pointer. When the only word left in the current chunk is the link word, the block reads that word instead. It then loads it as the new fetch pointer and starts counting the new chunk from zero.

The block also keeps a count of instructions in flight. The count rises when an instruction request is accepted and falls on a completion strobe. Fetching stalls while this count is saturated. A doorbell overflow wraps the pending count and raises a sticky flag.

Top module: `iq_chunk_fetch`

## Requirements
- R1: After reset the following are all zero: the queue enable, the pending count, the in-flight count, the fetch pointer, the chunk size and the overflow flag. No request is raised.
- R2: A write to register 3 adds bits [PEND_W-1:0] of the write data to the pending count, with the low three bits of the value ignored. A read of register 3 returns the pending count.
- R3: If the pending count passes 2^PEND_W-1, it wraps modulo 2^PEND_W and the sticky flag `dovf_o` is set. The flag is also readable as bit 0 of register 5. Writing register 5 with bit 0 set clears the flag.
- R4: An instruction request is raised when all of the following hold: the queue is enabled, no link read is outstanding, the pending count is at least 8, the in-flight count is below its maximum, and the chunk has more than 8 unconsumed words. The request address is the fetch pointer, 64-byte aligned, with `mem_req_link_o` low. On acceptance the pending count drops by 8 and the pointer advances by 64 bytes.
- R5: When the enabled queue has at least 8 pending words but 8 or fewer unconsumed words remain in the chunk, a read of the link word is raised at the fetch pointer, with `mem_req_link_o` high. After it is accepted, no request is raised until `mem_rsp_valid_i`. At that point bits [ADDR_W-1:6] of `mem_rsp_data_i` become the fetch pointer and chunk consumption restarts at zero.
- R6: The in-flight count rises by one on each accepted instruction request and falls by one on `done_i`. When both occur in the same cycle the count is unchanged. `done_i` at a count of zero is ignored. Register 4 reads the count.
- R7: No instruction request is raised while the in-flight count is at its maximum, 2^INFL_W-1.
- R8: A write to register 2 sets the fetch pointer from write data bits [ADDR_W-1:6] and restarts chunk consumption. A write to register 1 sets the chunk size in words from bits [SIZE_W-1:0] and also restarts consumption. A read of register 2 returns the next fetch address.
- R9: Writes to registers 1 and 2 are ignored unless three conditions hold: the queue is disabled, the in-flight count is zero, and no link read is outstanding.
- R10: Once raised and not accepted, a request keeps its valid, address and link flag until accepted, as long as no register write occurs.
- R11: Bit 0 of register 0 is the queue enable, and it is readable there. While it is clear no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select for write and read |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Read data of the selected register |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_req_addr_o | output | ADDR_W | Byte address of the request |
| mem_req_link_o | output | 1 | Request targets a link word |
| mem_rsp_valid_i | input | 1 | Link word returned |
| mem_rsp_data_i | input | DATA_W | Returned link word |
| done_i | input | 1 | One instruction completed |
| dovf_o | output | 1 | Doorbell overflow flag |

## Verification
The bench builds the block with an 8-bit pending count and a 3-bit in-flight count. With these widths a doorbell overflow takes two writes, and the in-flight ceiling of 7 is hit after seven instructions. Both would be out of practical reach at the default widths. The chunk size is left at 13 bits. The bench switches between a two-instruction chunk, where links are crossed often, and a twelve-instruction chunk, where the in-flight ceiling and a stalled request can be observed without a link read in the way.

// File: rtl/iq_chunk_fetch_pkg.sv
package iq_chunk_fetch_pkg;
  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_CHUNK = 3'd1,
    REG_START = 3'd2,
    REG_BELL  = 3'd3,
    REG_INFL  = 3'd4,
    REG_STAT  = 3'd5
  } iqf_reg_e;
  localparam int unsigned INSTR_WORDS = 8;
  localparam int unsigned LINE_SHIFT  = 6;
endpackage

// File: rtl/iqf_pend_ctr.sv
module iqf_pend_ctr #(
  parameter int unsigned PEND_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              add_en_i,
  input  logic [PEND_W-1:0] add_i,
  input  logic              take_i,
  input  logic              clr_flag_i,
  output logic [PEND_W-1:0] pend_o,
  output logic              ovf_o
);
  localparam int unsigned SUM_W = PEND_W + 2;

  logic [PEND_W-1:0] pend_q;
  logic              ovf_q;
  logic [PEND_W-1:0] add_masked;
  logic [SUM_W-1:0]  sum;

  always_comb begin
    add_masked = add_i & ~PEND_W'(7);
    sum = {2'b00, pend_q}
        + (add_en_i ? {2'b00, add_masked} : SUM_W'(0))
        - (take_i ? SUM_W'(8) : SUM_W'(0));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      pend_q <= sum[PEND_W-1:0];
      if (sum[SUM_W-1:PEND_W] != 2'b00) ovf_q <= 1'b1;
      else if (clr_flag_i)              ovf_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/iqf_infl_ctr.sv
module iqf_infl_ctr #(
  parameter int unsigned INFL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              done_i,
  output logic [INFL_W-1:0] cnt_o,
  output logic              full_o,
  output logic              zero_o
);
  logic [INFL_W-1:0] cnt_q;
  logic              dec;

  assign dec = done_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (inc_i && !dec)   cnt_q <= cnt_q + INFL_W'(1);
    else if (!inc_i && dec)   cnt_q <= cnt_q - INFL_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign full_o = &cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/iqf_chunk_walk.sv
module iqf_chunk_walk #(
  parameter int unsigned SIZE_W = 13,
  parameter int unsigned PTR_W  = 43
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              size_we_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              start_we_i,
  input  logic [PTR_W-1:0]  start_i,
  input  logic              step_i,
  input  logic              link_take_i,
  input  logic              rsp_valid_i,
  input  logic [PTR_W-1:0]  rsp_ptr_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [SIZE_W-1:0] size_o,
  output logic              need_link_o,
  output logic              link_wait_o
);
  logic [PTR_W-1:0]  ptr_q;
  logic [SIZE_W-1:0] size_q, widx_q, rem;
  logic              wait_q;

  // words left in chunk; only the link word remains when <= one instruction
  assign rem         = size_q - widx_q;
  assign need_link_o = (rem <= SIZE_W'(8));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      size_q <= '0;
      widx_q <= '0;
      wait_q <= 1'b0;
    end else begin
      if (size_we_i) begin
        size_q <= size_i;
        widx_q <= '0;
      end
      if (start_we_i) begin
        ptr_q  <= start_i;
        widx_q <= '0;
      end
      if (step_i) begin
        ptr_q  <= ptr_q + PTR_W'(1);
        widx_q <= widx_q + SIZE_W'(8);
      end
      if (link_take_i) wait_q <= 1'b1;
      if (rsp_valid_i && wait_q) begin
        ptr_q  <= rsp_ptr_i;
        widx_q <= '0;
        wait_q <= 1'b0;
      end
    end
  end

  assign ptr_o       = ptr_q;
  assign size_o      = size_q;
  assign link_wait_o = wait_q;
endmodule

// File: rtl/iq_chunk_fetch.sv
module iq_chunk_fetch
  import iq_chunk_fetch_pkg::*;
#(
  parameter int unsigned ADDR_W = 49,
  parameter int unsigned PEND_W = 20,
  parameter int unsigned INFL_W = 8,
  parameter int unsigned SIZE_W = 13,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic              mem_req_link_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rsp_data_i,
  input  logic              done_i,
  output logic              dovf_o
);
  localparam int unsigned PTR_W = ADDR_W - LINE_SHIFT;

  logic              ena_q;
  logic [PEND_W-1:0] pend_cnt;
  logic [INFL_W-1:0] infl_cnt;
  logic              infl_full, infl_zero;
  logic [PTR_W-1:0]  ptr;
  logic [SIZE_W-1:0] size;
  logic              need_link, link_wait;
  logic              quiet, have_work, fire, take_instr, take_link;
  logic              we_ctrl, we_chunk, we_start, we_bell, we_stat;
  logic              unused_bits;

  assign unused_bits = ^{reg_wdata_i, mem_rsp_data_i};

  assign we_ctrl  = reg_we_i && (reg_addr_i == REG_CTRL);
  assign we_chunk = reg_we_i && (reg_addr_i == REG_CHUNK);
  assign we_start = reg_we_i && (reg_addr_i == REG_START);
  assign we_bell  = reg_we_i && (reg_addr_i == REG_BELL);
  assign we_stat  = reg_we_i && (reg_addr_i == REG_STAT);

  // configuration only lands when nothing can be touching the queue
  assign quiet      = !ena_q && infl_zero && !link_wait;
  assign have_work  = (pend_cnt >= PEND_W'(INSTR_WORDS));
  assign mem_req_valid_o = ena_q && !link_wait && have_work && (need_link || !infl_full);
  assign mem_req_link_o  = need_link;
  assign mem_req_addr_o  = {ptr, {LINE_SHIFT{1'b0}}};
  assign fire       = mem_req_valid_o && mem_req_ready_i;
  assign take_instr = fire && !need_link;
  assign take_link  = fire && need_link;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ena_q <= 1'b0;
    else if (we_ctrl) ena_q <= reg_wdata_i[0];
  end

  iqf_pend_ctr #(.PEND_W(PEND_W)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .add_en_i   (we_bell),
    .add_i      (reg_wdata_i[PEND_W-1:0]),
    .take_i     (take_instr),
    .clr_flag_i (we_stat && reg_wdata_i[0]),
    .pend_o     (pend_cnt),
    .ovf_o      (dovf_o)
  );

  iqf_infl_ctr #(.INFL_W(INFL_W)) u_infl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (take_instr),
    .done_i (done_i),
    .cnt_o  (infl_cnt),
    .full_o (infl_full),
    .zero_o (infl_zero)
  );

  iqf_chunk_walk #(.SIZE_W(SIZE_W), .PTR_W(PTR_W)) u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .size_we_i   (we_chunk && quiet),
    .size_i      (reg_wdata_i[SIZE_W-1:0]),
    .start_we_i  (we_start && quiet),
    .start_i     (reg_wdata_i[ADDR_W-1:LINE_SHIFT]),
    .step_i      (take_instr),
    .link_take_i (take_link),
    .rsp_valid_i (mem_rsp_valid_i),
    .rsp_ptr_i   (mem_rsp_data_i[ADDR_W-1:LINE_SHIFT]),
    .ptr_o       (ptr),
    .size_o      (size),
    .need_link_o (need_link),
    .link_wait_o (link_wait)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      REG_CTRL:  reg_rdata_o = DATA_W'(ena_q);
      REG_CHUNK: reg_rdata_o = DATA_W'(size);
      REG_START: reg_rdata_o = DATA_W'(mem_req_addr_o);
      REG_BELL:  reg_rdata_o = DATA_W'(pend_cnt);
      REG_INFL:  reg_rdata_o = DATA_W'(infl_cnt);
      REG_STAT:  reg_rdata_o = DATA_W'(dovf_o);
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/iq_chunk_fetch_chk.sv
module iq_chunk_fetch_chk #(
  parameter int unsigned ADDR_W = 49,
  parameter int unsigned PEND_W = 20,
  parameter int unsigned INFL_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [2:0]        reg_addr_i,
  input logic              valid_i,
  input logic              ready_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              link_i,
  input logic              done_i,
  input logic              ena_i,
  input logic              link_wait_i,
  input logic [INFL_W-1:0] infl_i,
  input logic [PEND_W-1:0] pend_i
);
  // R10
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !ready_i && !reg_we_i |=> valid_i && $stable(addr_i) && $stable(link_i));

  // R7
  a_r7_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (&infl_i) |-> link_i);

  // R6
  a_r6_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_i && !link_i && !done_i |=> infl_i == $past(infl_i) + INFL_W'(1));

  // R5
  a_r5_wait_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_wait_i |-> !valid_i);

  // R11
  a_r11_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ena_i |-> !valid_i);

  // R2
  a_r2_pend_still: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == 3'd3) && !(valid_i && ready_i && !link_i)
    |=> pend_i == $past(pend_i));
endmodule

bind iq_chunk_fetch iq_chunk_fetch_chk #(
  .ADDR_W(ADDR_W), .PEND_W(PEND_W), .INFL_W(INFL_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .valid_i     (mem_req_valid_o),
  .ready_i     (mem_req_ready_i),
  .addr_i      (mem_req_addr_o),
  .link_i      (mem_req_link_o),
  .done_i      (done_i),
  .ena_i       (ena_q),
  .link_wait_i (link_wait),
  .infl_i      (infl_cnt),
  .pend_i      (pend_cnt)
);

// File: tb/iq_chunk_fetch_test.sv
module iq_chunk_fetch_test;
  localparam int AW = 49, PW = 8, IW = 3, SW = 13, DW = 64;
  localparam int PMAX = 1 << PW;
  localparam int IMAX = (1 << IW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, ready = 1'b0, rspv = 1'b0, done = 1'b0;
  logic [2:0] ra = '0;
  logic [DW-1:0] wd = '0, rspd = '0, rdata;
  logic valid, mlink, dovf;
  logic [AW-1:0] maddr;

  int n_chk = 0, n_fail = 0;
  string tag = "R1";

  bit m_ena, m_dovf, m_lw;
  int m_size, m_widx, m_pend, m_infl;
  longint m_ptr;

  always #5 clk = ~clk;

  iq_chunk_fetch #(.ADDR_W(AW), .PEND_W(PW), .INFL_W(IW), .SIZE_W(SW), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(ra), .reg_wdata_i(wd),
    .reg_rdata_o(rdata), .mem_req_valid_o(valid), .mem_req_ready_i(ready),
    .mem_req_addr_o(maddr), .mem_req_link_o(mlink), .mem_rsp_valid_i(rspv),
    .mem_rsp_data_i(rspd), .done_i(done), .dovf_o(dovf));

  task automatic chk(string t, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", t, what, act, exp);
    end
  endtask

  task automatic model_comb(output bit ev, output bit el, output logic [63:0] ea,
                            output logic [63:0] er);
    bit need;
    need = (m_size - m_widx) <= 8;
    ev = m_ena && !m_lw && m_pend >= 8 && (need || m_infl < IMAX);
    el = need;
    ea = 64'(m_ptr) << 6;
    case (ra)
      3'd0: er = 64'(m_ena);
      3'd1: er = 64'(m_size);
      3'd2: er = 64'(m_ptr) << 6;
      3'd3: er = 64'(m_pend);
      3'd4: er = 64'(m_infl);
      3'd5: er = 64'(m_dovf);
      default: er = '0;
    endcase
  endtask

  task automatic model_update(bit ev, bit el);
    bit fire, quiet, lw0;
    int add, t;
    fire  = ev && ready;
    quiet = !m_ena && m_infl == 0 && !m_lw;
    lw0   = m_lw;
    add = (we && ra == 3'd3) ? int'(wd[PW-1:0] & 8'hF8) : 0;
    t = m_pend + add - ((fire && !el) ? 8 : 0);
    if (t >= PMAX) begin m_dovf = 1; t -= PMAX; end
    else if (we && ra == 3'd5 && wd[0]) m_dovf = 0;
    m_pend = t;
    m_infl = m_infl + ((fire && !el) ? 1 : 0) - ((done && m_infl != 0) ? 1 : 0);
    if (we && ra == 3'd1 && quiet) begin m_size = int'(wd[SW-1:0]); m_widx = 0; end
    if (we && ra == 3'd2 && quiet) begin m_ptr = longint'(wd[AW-1:6]); m_widx = 0; end
    if (fire && !el) begin m_ptr++; m_widx += 8; end
    if (fire && el) m_lw = 1;
    if (rspv && lw0) begin m_ptr = longint'(rspd[AW-1:6]); m_widx = 0; m_lw = 0; end
    if (we && ra == 3'd0) m_ena = wd[0];
  endtask

  task automatic step();
    bit ev, el;
    logic [63:0] ea, er;
    #1;
    model_comb(ev, el, ea, er);
    chk(tag, "req_valid", 64'(valid), 64'(ev));
    if (ev) begin
      chk(tag, "req_addr", 64'(maddr), ea);
      chk(tag, "req_link", 64'(mlink), 64'(el));
    end
    chk(tag, "rdata", rdata, er);
    chk(tag, "dovf", 64'(dovf), 64'(m_dovf));
    @(posedge clk);
    model_update(ev, el);
    @(negedge clk);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(logic [2:0] a, logic [63:0] d);
    we = 1'b1; ra = a; wd = d;
    step();
    we = 1'b0;
  endtask

  task automatic look(logic [2:0] a);
    ra = a;
    #1;
  endtask

  task automatic link_rsp(logic [63:0] d);
    rspv = 1'b1; rspd = d;
    step();
    rspv = 1'b0;
  endtask

  initial begin
    m_ena = 0; m_dovf = 0; m_lw = 0; m_size = 0; m_widx = 0; m_pend = 0; m_infl = 0; m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    tag = "R1";
    look(3'd1);
    chk("R1", "valid", 64'(valid), 0);
    chk("R1", "chunk", rdata, 0);
    for (int a = 0; a < 6; a++) begin ra = 3'(a); step(); end
    // R8 configure
    tag = "R8";
    wr(3'd2, 64'h1000);
    wr(3'd1, 64'd17);
    look(3'd2);
    chk("R8", "start_rd", rdata, 64'h1000);
    // R2 doorbell, low bits ignored
    tag = "R2";
    wr(3'd3, 64'h13);
    look(3'd3);
    chk("R2", "pending", rdata, 64'h10);
    // R4 / R11 enable and fetch
    tag = "R4";
    ready = 1'b1;
    wr(3'd0, 64'd1);
    look(3'd0);
    chk("R11", "ena_rd", rdata, 1);
    chk("R4", "valid", 64'(valid), 1);
    chk("R4", "addr0", 64'(maddr), 64'h1000);
    chk("R4", "link0", 64'(mlink), 0);
    step();
    look(3'd3);
    chk("R4", "addr1", 64'(maddr), 64'h1040);
    chk("R4", "pend_after1", rdata, 64'h8);
    step();
    look(3'd4);
    chk("R4", "idle_no_work", 64'(valid), 0);
    chk("R6", "infl2", rdata, 2);
    // R5 link crossing
    tag = "R5";
    wr(3'd3, 64'd24);
    look(3'd2);
    chk("R5", "link_valid", 64'(valid), 1);
    chk("R5", "link_flag", 64'(mlink), 1);
    chk("R5", "link_addr", 64'(maddr), 64'h1080);
    step();
    look(3'd2);
    chk("R5", "blocked_wait", 64'(valid), 0);
    steps(2);
    link_rsp(64'h203F);
    look(3'd2);
    chk("R5", "new_chunk_addr", 64'(maddr), 64'h2000);
    chk("R5", "new_chunk_link", 64'(mlink), 0);
    chk("R8", "next_ptr_rd", rdata, 64'h2000);
    steps(2);
    look(3'd2);
    chk("R5", "link2_addr", 64'(maddr), 64'h2080);
    chk("R5", "link2_flag", 64'(mlink), 1);
    step();
    link_rsp(64'h3000);
    look(3'd2);
    chk("R5", "chunk3_addr", 64'(maddr), 64'h3000);
    step();
    // R9 config writes ignored while enabled
    tag = "R9";
    wr(3'd1, 64'd97);
    wr(3'd2, 64'h8000);
    look(3'd1);
    chk("R9", "chunk_kept", rdata, 64'd17);
    look(3'd2);
    chk("R9", "start_kept", rdata, 64'h3040);
    // R6 completions, including one at zero
    tag = "R6";
    done = 1'b1; ra = 3'd4;
    steps(6);
    done = 1'b0;
    look(3'd4);
    chk("R6", "infl_zero", rdata, 0);
    // R11 disable, reconfigure
    tag = "R11";
    wr(3'd0, 64'd0);
    wr(3'd1, 64'd97);
    wr(3'd2, 64'h10000);
    look(3'd1);
    chk("R9", "chunk_taken_quiet", rdata, 64'd97);
    // R7 in-flight ceiling
    tag = "R7";
    wr(3'd3, 64'd80);
    look(3'd3);
    chk("R11", "no_req_disabled", 64'(valid), 0);
    wr(3'd0, 64'd1);
    steps(10);
    look(3'd4);
    chk("R7", "infl_max", rdata, 64'(IMAX));
    chk("R7", "stalled", 64'(valid), 0);
    look(3'd3);
    chk("R7", "pend_left", rdata, 64'd24);
    tag = "R6";
    done = 1'b1;
    step();
    step();
    done = 1'b0;
    look(3'd4);
    chk("R6", "inc_dec_same", rdata, 64'd6);
    step();
    // R10 hold while not accepted
    tag = "R10";
    ready = 1'b0;
    done = 1'b1;
    step();
    done = 1'b0;
    steps(4);
    look(3'd3);
    chk("R10", "held_valid", 64'(valid), 1);
    chk("R10", "held_addr", 64'(maddr), 64'h10240);
    ready = 1'b1;
    step();
    // R3 overflow
    tag = "R3";
    wr(3'd0, 64'd0);
    wr(3'd3, 64'd248);
    wr(3'd3, 64'd16);
    look(3'd3);
    chk("R3", "flag", 64'(dovf), 1);
    chk("R3", "wrapped", rdata, 64'd8);
    wr(3'd3, 64'(PMAX - 8));
    look(3'd3);
    chk("R3", "back_to_zero", rdata, 0);
    wr(3'd5, 64'd1);
    look(3'd5);
    chk("R3", "cleared", 64'(dovf), 0);
    chk("R3", "stat_rd", rdata, 0);
    tag = "R2";
    wr(3'd3, 64'd7);
    look(3'd3);
    chk("R2", "low_bits_ignored", rdata, 0);
    steps(2);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule